// File: doc/BRIEF.md
# Receive Packet Status Queue

This block keeps one 16-bit status word per received packet, for up to eight packets. It sits between a receive datapath and a host. The datapath pulses `pkt_start` when a packet begins, `pkt_byte` for every byte that arrives, and `pkt_end` with a 4-bit error kind when the packet closes. The host sees the oldest word on `top_status`, reads packet bytes with `host_rd`, and removes the oldest packet with `host_discard`.

The packet data store is modelled only as a byte occupancy (`store_level`). Bytes held by a packet stay counted until that packet is discarded. The word at the top is live: while its packet is still arriving it shows the incomplete bit and a byte count that grows. Three diagnostic flags are provided:
- `stat_ovf` marks a packet that was refused because eight were already queued.
- `store_ovf` marks a full data store and clears with hysteresis.
- `underrun_fail` is a sticky adapter-failure flag, raised when the host reads past the data of the top packet.

A receive state machine with three states decides what happens to each incoming packet:
- IDLE: no packet is arriving.
- RECV: a packet is being recorded in the newest entry.
- DROP: the rest of a packet is thrown away.

Its transitions are:
- accept, IDLE to RECV: a start is taken.
- refuse, IDLE to DROP: a start arrives while the queue or the store is full.
- close, RECV to IDLE: the packet ends.
- evict, RECV to DROP: the host discards the packet while it is still arriving.
- flush, DROP to IDLE: the end of a dropped packet.

A `rx_reset` pulse, or `rst_n` low, returns every state to empty.

Top module: `rx_status_queue`

## Requirements
- R1: When the queue is empty, `top_status` reads 16'h8000. After reset the queue is empty, every flag is low and `store_level` is 0.
- R2: An accepted packet gets a new entry. While it is the top entry, bit 15 of the word is 1, bits 14:11 are 0, and bits 10:0 count the bytes stored so far. `receiving` is high while the packet is in RECV.
- R3: On `pkt_end` the entry becomes complete: bit 15 goes to 0 and bits 14:11 take the error kind. The kinds 1000, 1011, 1100, 1101, 1001 and 0010 are kept as given; every other kind is stored as 0000. `rx_done` is high for exactly one cycle, in the first cycle in which the completed word is visible.
- R4: A packet never counts more than 1514 bytes. Bytes that arrive after the count reaches 1514 are not counted, and the entry completes with kind 1001, whatever kind came with `pkt_end`.
- R5: Entries leave in arrival order. A discard on an empty queue changes nothing.
- R6: A start that arrives while 8 entries are queued is refused: the entries are left unchanged, and the bytes and end of that packet have no effect. `stat_ovf` rises on the refusal and falls on the next discard.
- R7: `store_level` is the sum of the byte counts of all queued entries. When it reaches 2048, `store_ovf` rises. While the store is at 2048 no further bytes are counted, and while `store_ovf` is high new starts are refused. `store_ovf` falls once `store_level` is at or below 2032.
- R8: A `host_rd` pulse fetches the next byte of the top packet. A read when the queue is empty, or when all of the top packet's counted bytes have already been read, sets `underrun_fail`. The flag stays set through discards.
- R9: Discarding a packet that is still arriving removes its entry at once. The rest of that packet is dropped, `receiving` falls and no `rx_done` follows.
- R10: A `rx_reset` pulse empties the queue, zeroes `store_level` and clears all three flags in the next cycle.
- R11: A discard frees the byte count of the removed packet in the same clock edge that removes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_reset | input | 1 | Synchronous receive reset command |
| pkt_start | input | 1 | A new packet begins |
| pkt_byte | input | 1 | One byte of the current packet arrives |
| pkt_end | input | 1 | The current packet ends |
| pkt_err | input | 4 | Error kind that goes with `pkt_end` |
| host_discard | input | 1 | Remove the oldest entry |
| host_rd | input | 1 | Host reads one byte of the top packet |
| top_status | output | 16 | Status word of the oldest entry |
| queue_count | output | 4 | Number of queued entries |
| store_level | output | 12 | Bytes held by the queued packets |
| stat_ovf | output | 1 | A packet was refused because the queue was full |
| store_ovf | output | 1 | The data store is full (with hysteresis) |
| underrun_fail | output | 1 | Sticky flag: the host read past the packet data |
| receiving | output | 1 | A packet is being recorded |
| rx_done | output | 1 | One-cycle pulse when a packet completes |

## Verification
The properties assume the datapath frames packets: it drives `pkt_byte` and `pkt_end` only after a `pkt_start`, and the start or end of a refused packet is treated like any other. Inputs arriving in any combination, including at the same time as a discard or a reset, are also within what the properties expect. The random stimulus draws all seven inputs independently every cycle, so it also produces starts during a packet and ends with no packet, which the state machine must ignore. A reference model in the bench applies the same rules to those cases. Directed sequences take the queue to exactly eight entries, the store to exactly 2048 bytes and a packet to past 1514 bytes.

// File: rtl/rxq_pkg.sv
`timescale 1ns/1ps
package rxq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RECV = 2'd1,
        ST_DROP = 2'd2
    } rx_state_e;

    localparam logic [3:0] KIND_NONE     = 4'b0000;
    localparam logic [3:0] KIND_OVERRUN  = 4'b1000;
    localparam logic [3:0] KIND_OVERSIZE = 4'b1001;
    localparam logic [3:0] KIND_RUNT     = 4'b1011;
    localparam logic [3:0] KIND_ALIGN    = 4'b1100;
    localparam logic [3:0] KIND_CRC      = 4'b1101;
    localparam logic [3:0] KIND_DRIBBLE  = 4'b0010;

    // Keep the listed error kinds; every other code becomes "no error".
    function automatic logic [3:0] keep_known(input logic [3:0] kind);
        logic [3:0] res;
        case (kind)
            KIND_OVERRUN, KIND_OVERSIZE, KIND_RUNT,
            KIND_ALIGN, KIND_CRC, KIND_DRIBBLE: res = kind;
            default:                            res = KIND_NONE;
        endcase
        return res;
    endfunction

endpackage

// File: rtl/rxq_fsm.sv
`timescale 1ns/1ps
module rxq_fsm
    import rxq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic rx_start,
    input  logic rx_byte,
    input  logic rx_end,
    input  logic q_full,
    input  logic store_full,
    input  logic pop_live,
    output logic push,
    output logic reject_full,
    output logic byte_ok,
    output logic finish,
    output logic receiving
);

    rx_state_e state, state_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   state <= ST_IDLE;
        else if (clr) state <= ST_IDLE;
        else          state <= state_n;
    end

    // Next state
    always_comb begin
        state_n = state;
        unique case (state)
            ST_IDLE: begin
                if (rx_start) state_n = (q_full || store_full) ? ST_DROP : ST_RECV;
            end
            ST_RECV: begin
                if (rx_end)        state_n = ST_IDLE;   // close
                else if (pop_live) state_n = ST_DROP;   // evict
            end
            ST_DROP: begin
                if (rx_end) state_n = ST_IDLE;          // flush
            end
            default: state_n = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        push        = 1'b0;
        reject_full = 1'b0;
        byte_ok     = 1'b0;
        finish      = 1'b0;
        receiving   = 1'b0;
        unique case (state)
            ST_IDLE: begin
                push        = rx_start && !q_full && !store_full;
                reject_full = rx_start && q_full;
            end
            ST_RECV: begin
                receiving = 1'b1;
                byte_ok   = rx_byte && !pop_live;
                finish    = rx_end && !pop_live;
            end
            ST_DROP: ;
            default: ;
        endcase
    end

endmodule

// File: rtl/rxq_queue.sv
`timescale 1ns/1ps
module rxq_queue
    import rxq_pkg::*;
#(
    parameter  int DEPTH = 8,
    parameter  int LEN_W = 11,
    localparam int AW    = $clog2(DEPTH),
    localparam int CW    = AW + 1
)(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             push,
    input  logic             pop,
    input  logic             grow,
    input  logic             over,
    input  logic             finish,
    input  logic [3:0]       kind_in,
    output logic [LEN_W-1:0] head_len,
    output logic [3:0]       head_kind,
    output logic             head_done,
    output logic [LEN_W-1:0] tail_len,
    output logic [CW-1:0]    count
);

    logic [LEN_W-1:0] len_q  [DEPTH];
    logic [3:0]       kind_q [DEPTH];
    logic             done_q [DEPTH];
    logic             big_q  [DEPTH];
    logic [AW-1:0]    head, tail, last;

    assign last = tail - 1'b1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            head  <= '0;
            tail  <= '0;
            count <= '0;
        end else if (clr) begin
            head  <= '0;
            tail  <= '0;
            count <= '0;
        end else begin
            if (pop)  head <= head + 1'b1;
            if (push) tail <= tail + 1'b1;
            count <= count + CW'(push) - CW'(pop);
        end
    end

    for (genvar gi = 0; gi < DEPTH; gi++) begin : g_entry
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                len_q[gi]  <= '0;
                kind_q[gi] <= '0;
                done_q[gi] <= 1'b0;
                big_q[gi]  <= 1'b0;
            end else if (clr) begin
                len_q[gi]  <= '0;
                kind_q[gi] <= '0;
                done_q[gi] <= 1'b0;
                big_q[gi]  <= 1'b0;
            end else if (push && tail == AW'(gi)) begin
                len_q[gi]  <= '0;
                kind_q[gi] <= '0;
                done_q[gi] <= 1'b0;
                big_q[gi]  <= 1'b0;
            end else if (last == AW'(gi)) begin
                if (grow) len_q[gi] <= len_q[gi] + 1'b1;
                if (over) big_q[gi] <= 1'b1;
                if (finish) begin
                    done_q[gi] <= 1'b1;
                    kind_q[gi] <= (big_q[gi] || over) ? KIND_OVERSIZE : keep_known(kind_in);
                end
            end
        end
    end

    assign head_len  = len_q[head];
    assign head_kind = kind_q[head];
    assign head_done = done_q[head];
    assign tail_len  = len_q[last];

endmodule

// File: rtl/rxq_flags.sv
`timescale 1ns/1ps
module rxq_flags #(
    parameter int STORE_BYTES   = 2048,
    parameter int RESUME_MARGIN = 16,
    parameter int LEN_W         = 11,
    parameter int LVL_W         = 12
)(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             take,
    input  logic             pop,
    input  logic             reject_full,
    input  logic             host_rd,
    input  logic             q_empty,
    input  logic [LEN_W-1:0] head_len,
    output logic [LVL_W-1:0] level,
    output logic             store_ovf,
    output logic             stat_ovf,
    output logic             underrun
);

    logic [LVL_W-1:0] lvl_n;
    logic [LEN_W-1:0] rd_cnt;
    logic             rd_bad;

    assign lvl_n  = level + LVL_W'(take) - (pop ? LVL_W'(head_len) : LVL_W'(0));
    assign rd_bad = host_rd && (q_empty || rd_cnt >= head_len);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            level     <= '0;
            store_ovf <= 1'b0;
            stat_ovf  <= 1'b0;
            underrun  <= 1'b0;
            rd_cnt    <= '0;
        end else if (clr) begin
            level     <= '0;
            store_ovf <= 1'b0;
            stat_ovf  <= 1'b0;
            underrun  <= 1'b0;
            rd_cnt    <= '0;
        end else begin
            level <= lvl_n;
            if (lvl_n == LVL_W'(STORE_BYTES))                      store_ovf <= 1'b1;
            else if (lvl_n <= LVL_W'(STORE_BYTES - RESUME_MARGIN)) store_ovf <= 1'b0;
            if (pop)              stat_ovf <= 1'b0;
            else if (reject_full) stat_ovf <= 1'b1;
            if (rd_bad) underrun <= 1'b1;
            if (pop)                   rd_cnt <= '0;
            else if (host_rd && !rd_bad) rd_cnt <= rd_cnt + 1'b1;
        end
    end

endmodule

// File: rtl/rx_status_queue.sv
`timescale 1ns/1ps
module rx_status_queue #(
    parameter  int DEPTH         = 8,
    parameter  int STORE_BYTES   = 2048,
    parameter  int MAX_LEN       = 1514,
    parameter  int RESUME_MARGIN = 16,
    localparam int LEN_W         = 11,
    localparam int CW            = $clog2(DEPTH) + 1,
    localparam int LVL_W         = $clog2(STORE_BYTES + 1)
)(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_reset,
    input  logic             pkt_start,
    input  logic             pkt_byte,
    input  logic             pkt_end,
    input  logic [3:0]       pkt_err,
    input  logic             host_discard,
    input  logic             host_rd,
    output logic [15:0]      top_status,
    output logic [CW-1:0]    queue_count,
    output logic [LVL_W-1:0] store_level,
    output logic             stat_ovf,
    output logic             store_ovf,
    output logic             underrun_fail,
    output logic             receiving,
    output logic             rx_done
);

    logic             push, reject_full, byte_ok, finish;
    logic             pop, pop_live, q_full, take, over;
    logic [LEN_W-1:0] head_len, tail_len;
    logic [3:0]       head_kind;
    logic             head_done;

    assign pop      = host_discard && (queue_count != '0);
    assign pop_live = pop && !head_done;
    assign q_full   = (queue_count == CW'(DEPTH));
    assign take     = byte_ok && (tail_len < LEN_W'(MAX_LEN)) && (store_level < LVL_W'(STORE_BYTES));
    assign over     = byte_ok && (tail_len == LEN_W'(MAX_LEN));

    rxq_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .clr         (rx_reset),
        .rx_start    (pkt_start),
        .rx_byte     (pkt_byte),
        .rx_end      (pkt_end),
        .q_full      (q_full),
        .store_full  (store_ovf),
        .pop_live    (pop_live),
        .push        (push),
        .reject_full (reject_full),
        .byte_ok     (byte_ok),
        .finish      (finish),
        .receiving   (receiving)
    );

    rxq_queue #(.DEPTH(DEPTH), .LEN_W(LEN_W)) u_queue (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (rx_reset),
        .push      (push),
        .pop       (pop),
        .grow      (take),
        .over      (over),
        .finish    (finish),
        .kind_in   (pkt_err),
        .head_len  (head_len),
        .head_kind (head_kind),
        .head_done (head_done),
        .tail_len  (tail_len),
        .count     (queue_count)
    );

    rxq_flags #(
        .STORE_BYTES   (STORE_BYTES),
        .RESUME_MARGIN (RESUME_MARGIN),
        .LEN_W         (LEN_W),
        .LVL_W         (LVL_W)
    ) u_flags (
        .clk         (clk),
        .rst_n       (rst_n),
        .clr         (rx_reset),
        .take        (take),
        .pop         (pop),
        .reject_full (reject_full),
        .host_rd     (host_rd),
        .q_empty     (queue_count == '0),
        .head_len    (head_len),
        .level       (store_level),
        .store_ovf   (store_ovf),
        .stat_ovf    (stat_ovf),
        .underrun    (underrun_fail)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        rx_done <= 1'b0;
        else if (rx_reset) rx_done <= 1'b0;
        else               rx_done <= finish;
    end

    always_comb begin
        if (queue_count == '0) top_status = 16'h8000;
        else top_status = {~head_done, (head_done ? head_kind : 4'h0), head_len};
    end

endmodule

// File: rtl/rxq_checker.sv
`timescale 1ns/1ps
module rxq_checker #(
    parameter int DEPTH       = 8,
    parameter int STORE_BYTES = 2048,
    parameter int MAX_LEN     = 1514
)(
    input logic                               clk,
    input logic                               rst_n,
    input logic                               rx_reset,
    input logic [15:0]                        top_status,
    input logic [$clog2(DEPTH):0]             queue_count,
    input logic [$clog2(STORE_BYTES+1)-1:0]   store_level,
    input logic                               stat_ovf,
    input logic                               underrun_fail,
    input logic                               receiving,
    input logic                               rx_done
);

    a_r1_empty_word: assert property (@(posedge clk) disable iff (!rst_n)
        queue_count == '0 |-> top_status == 16'h8000);

    a_r2_live_entry: assert property (@(posedge clk) disable iff (!rst_n)
        receiving |-> queue_count != '0);

    a_r3_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        rx_done |-> !receiving);

    a_r4_len_cap: assert property (@(posedge clk) disable iff (!rst_n)
        top_status[10:0] <= 11'(MAX_LEN));

    a_r6_count_cap: assert property (@(posedge clk) disable iff (!rst_n)
        queue_count <= ($clog2(DEPTH)+1)'(DEPTH));

    a_r6_flag_full: assert property (@(posedge clk) disable iff (!rst_n)
        stat_ovf |-> queue_count == ($clog2(DEPTH)+1)'(DEPTH));

    a_r7_level_cap: assert property (@(posedge clk) disable iff (!rst_n)
        store_level <= ($clog2(STORE_BYTES+1))'(STORE_BYTES));

    a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        underrun_fail && !rx_reset |=> underrun_fail);

    a_r10_clear: assert property (@(posedge clk) disable iff (!rst_n)
        rx_reset |=> queue_count == '0 && store_level == '0 && !underrun_fail && !stat_ovf);

endmodule

bind rx_status_queue rxq_checker #(
    .DEPTH       (DEPTH),
    .STORE_BYTES (STORE_BYTES),
    .MAX_LEN     (MAX_LEN)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .rx_reset      (rx_reset),
    .top_status    (top_status),
    .queue_count   (queue_count),
    .store_level   (store_level),
    .stat_ovf      (stat_ovf),
    .underrun_fail (underrun_fail),
    .receiving     (receiving),
    .rx_done       (rx_done)
);

// File: tb/tb_rx_status_queue.sv
`timescale 1ns/1ps
module tb_rx_status_queue;
    localparam int DEPTH  = 8;
    localparam int STORE  = 2048;
    localparam int MAXL   = 1514;
    localparam int MARGIN = 16;

    logic clk = 1'b0, rst_n = 1'b0, rx_reset = 1'b0;
    logic pkt_start = 1'b0, pkt_byte = 1'b0, pkt_end = 1'b0;
    logic [3:0] pkt_err = 4'h0;
    logic host_discard = 1'b0, host_rd = 1'b0;
    logic [15:0] top_status;
    logic [3:0]  queue_count;
    logic [11:0] store_level;
    logic stat_ovf, store_ovf, underrun_fail, receiving, rx_done;

    int nchecks = 0, nerrs = 0;

    always #2.5 clk = ~clk;

    rx_status_queue dut (
        .clk(clk), .rst_n(rst_n), .rx_reset(rx_reset),
        .pkt_start(pkt_start), .pkt_byte(pkt_byte), .pkt_end(pkt_end), .pkt_err(pkt_err),
        .host_discard(host_discard), .host_rd(host_rd),
        .top_status(top_status), .queue_count(queue_count), .store_level(store_level),
        .stat_ovf(stat_ovf), .store_ovf(store_ovf), .underrun_fail(underrun_fail),
        .receiving(receiving), .rx_done(rx_done)
    );

    // Reference model
    int m_len [DEPTH];
    int m_kind[DEPTH];
    bit m_done[DEPTH];
    bit m_big [DEPTH];
    int m_cnt = 0, m_state = 0, m_level = 0, m_rd = 0;
    bit m_sovf = 0, m_stov = 0, m_und = 0, m_rxd = 0;

    function automatic int norm(input int k);
        case (k)
            8, 9, 11, 12, 13, 2: return k;
            default:             return 0;
        endcase
    endfunction

    function automatic logic [15:0] exp_status();
        logic [15:0] w;
        if (m_cnt == 0) return 16'h8000;
        w = 16'(m_len[0]) & 16'h07FF;
        if (m_done[0]) w = w | 16'(m_kind[0] << 11);
        else           w = w | 16'h8000;
        return w;
    endfunction

    task automatic model_step(input bit s, input bit b, input bit e, input int k,
                              input bit d, input bit h, input bit r);
        bit pop, pl, push, rejq, bok, fin, take, over, bad;
        int nst, t, lvl_n, plen;
        if (r) begin
            m_cnt = 0; m_state = 0; m_level = 0; m_rd = 0;
            m_sovf = 0; m_stov = 0; m_und = 0; m_rxd = 0;
            return;
        end
        pop  = d && m_cnt > 0;
        pl   = pop && !m_done[0];
        bad  = h && (m_cnt == 0 || m_rd >= m_len[0]);
        plen = pop ? m_len[0] : 0;
        push = 0; rejq = 0; bok = 0; fin = 0; nst = m_state;
        case (m_state)
            0: if (s) begin
                   if (m_cnt == DEPTH) begin rejq = 1; nst = 2; end
                   else if (m_sovf) nst = 2;
                   else begin push = 1; nst = 1; end
               end
            1: begin
                   bok = b && !pl; fin = e && !pl;
                   if (e) nst = 0; else if (pl) nst = 2;
               end
            default: if (e) nst = 0;
        endcase
        t = m_cnt - 1;
        take = 0; over = 0;
        if (bok) begin
            take = (m_len[t] < MAXL) && (m_level < STORE);
            over = (m_len[t] == MAXL);
            if (take) m_len[t]++;
            if (over) m_big[t] = 1;
        end
        if (fin) begin
            m_done[t] = 1;
            m_kind[t] = m_big[t] ? 9 : norm(k);
        end
        lvl_n = m_level + int'(take) - plen;
        if (lvl_n == STORE) m_sovf = 1;
        else if (lvl_n <= STORE - MARGIN) m_sovf = 0;
        if (pop) m_stov = 0; else if (rejq) m_stov = 1;
        if (bad) m_und = 1;
        if (pop) m_rd = 0; else if (h && !bad) m_rd++;
        if (pop) begin
            for (int i = 0; i < DEPTH - 1; i++) begin
                m_len[i] = m_len[i+1]; m_kind[i] = m_kind[i+1];
                m_done[i] = m_done[i+1]; m_big[i] = m_big[i+1];
            end
            m_cnt--;
        end
        if (push) begin
            m_len[m_cnt] = 0; m_kind[m_cnt] = 0; m_done[m_cnt] = 0; m_big[m_cnt] = 0;
            m_cnt++;
        end
        m_level = lvl_n;
        m_state = nst;
        m_rxd   = fin;
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        nchecks++;
        if (act !== exp) begin
            nerrs++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic compare();
        chk("R2/R3 top_status", int'(top_status), int'(exp_status()));
        chk("R5 queue_count", int'(queue_count), m_cnt);
        chk("R7 store_level", int'(store_level), m_level);
        chk("R6 stat_ovf", int'(stat_ovf), int'(m_stov));
        chk("R7 store_ovf", int'(store_ovf), int'(m_sovf));
        chk("R8 underrun_fail", int'(underrun_fail), int'(m_und));
        chk("R2 receiving", int'(receiving), int'(m_state == 1));
        chk("R3 rx_done", int'(rx_done), int'(m_rxd));
    endtask

    task automatic cyc(input bit s, input bit b, input bit e, input int k,
                       input bit d, input bit h, input bit r);
        @(negedge clk);
        pkt_start = s; pkt_byte = b; pkt_end = e; pkt_err = 4'(k);
        host_discard = d; host_rd = h; rx_reset = r;
        @(posedge clk);
        #1;
        model_step(s, b, e, k, d, h, r);
        compare();
    endtask

    task automatic idle();
        cyc(0, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic bytes(input int n);
        for (int i = 0; i < n; i++) cyc(0, 1, 0, 0, 0, 0, 0);
    endtask

    task automatic packet(input int n, input int k);
        cyc(1, 0, 0, 0, 0, 0, 0);
        bytes(n);
        cyc(0, 0, 1, k, 0, 0, 0);
    endtask

    initial begin
        #1_000_000;
        nerrs++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", nchecks, nerrs);
        $finish;
    end

    initial begin
        void'($urandom(32'd4321));
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        #1;
        // R1 reset state
        chk("R1 empty word", int'(top_status), 16'h8000);
        chk("R1 count after reset", int'(queue_count), 0);
        chk("R1 flags after reset", int'({stat_ovf, store_ovf, underrun_fail, rx_done}), 0);
        idle();

        // R2 live word, R3 completion
        cyc(1, 0, 0, 0, 0, 0, 0);
        bytes(3);
        chk("R2 live count", int'(top_status), 16'h8003);
        chk("R2 receiving high", int'(receiving), 1);
        bytes(2);
        cyc(0, 0, 1, 13, 0, 0, 0);
        chk("R3 crc word", int'(top_status), 16'h6805);
        chk("R3 done pulse", int'(rx_done), 1);
        idle();
        chk("R3 done one cycle", int'(rx_done), 0);

        // R3 unknown kind, R5 order
        packet(4, 5);
        chk("R5 head unchanged", int'(top_status), 16'h6805);
        cyc(0, 0, 0, 0, 1, 0, 0);
        chk("R3 unknown kind cleared", int'(top_status), 16'h0004);
        cyc(0, 0, 0, 0, 1, 0, 0);
        chk("R5 empty after pops", int'(top_status), 16'h8000);
        cyc(0, 0, 0, 0, 1, 0, 0);
        chk("R5 empty discard", int'(queue_count), 0);

        // R4 oversize
        packet(1520, 13);
        chk("R4 oversize word", int'(top_status), 16'h4DEA);
        chk("R7 level sum", int'(store_level), 1514);
        cyc(0, 0, 0, 0, 1, 0, 0);
        chk("R11 level freed", int'(store_level), 0);

        // R6 eight entry limit
        for (int i = 0; i < DEPTH; i++) packet(2, 2);
        chk("R6 full count", int'(queue_count), 8);
        packet(3, 0);
        chk("R6 stat_ovf set", int'(stat_ovf), 1);
        chk("R6 entries kept", int'(queue_count), 8);
        chk("R6 level kept", int'(store_level), 16);
        chk("R6 head kept", int'(top_status), 16'h1002);
        cyc(0, 0, 0, 0, 1, 0, 0);
        chk("R6 stat_ovf cleared", int'(stat_ovf), 0);

        // R10 receive reset
        cyc(0, 0, 0, 0, 0, 0, 1);
        chk("R10 reset count", int'(queue_count), 0);
        chk("R10 reset level", int'(store_level), 0);

        // R7 store full
        packet(1100, 0);
        cyc(1, 0, 0, 0, 0, 0, 0);
        bytes(960);
        cyc(0, 0, 1, 0, 0, 0, 0);
        chk("R7 level at cap", int'(store_level), 2048);
        chk("R7 store_ovf set", int'(store_ovf), 1);
        chk("R7 bytes stop", int'(queue_count), 2);
        packet(2, 0);
        chk("R7 start refused", int'(queue_count), 2);
        cyc(0, 0, 0, 0, 1, 0, 0);
        chk("R7 store_ovf cleared", int'(store_ovf), 0);
        chk("R11 level after pop", int'(store_level), 948);

        // R8 underrun
        for (int i = 0; i < 948; i++) cyc(0, 0, 0, 0, 0, 1, 0);
        chk("R8 no underrun within", int'(underrun_fail), 0);
        cyc(0, 0, 0, 0, 0, 1, 0);
        chk("R8 underrun set", int'(underrun_fail), 1);
        cyc(0, 0, 0, 0, 1, 0, 0);
        chk("R8 sticky through pop", int'(underrun_fail), 1);
        cyc(0, 0, 0, 0, 0, 0, 1);
        chk("R10 underrun cleared", int'(underrun_fail), 0);

        // R9 discard of a live packet
        cyc(1, 0, 0, 0, 0, 0, 0);
        bytes(3);
        cyc(0, 1, 0, 0, 1, 0, 0);
        chk("R9 entry removed", int'(queue_count), 0);
        chk("R9 receiving low", int'(receiving), 0);
        bytes(2);
        cyc(0, 0, 1, 0, 0, 0, 0);
        chk("R9 no done pulse", int'(rx_done), 0);
        packet(2, 0);
        chk("R9 next packet clean", int'(top_status), 16'h0002);

        // Random phase
        for (int n = 0; n < 5000; n++) begin
            cyc(($urandom % 20) == 0, ($urandom % 2) == 0, ($urandom % 40) == 0,
                int'($urandom % 16), ($urandom % 15) == 0, ($urandom % 5) == 0,
                ($urandom % 700) == 0);
        end
        idle();

        $display("Simulation finished: %0d checks, %0d errors", nchecks, nerrs);
        $finish;
    end
endmodule